// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Register Bank

This block is the software-visible register bank of a DRAM controller's control plane. It sits on a simple 32-bit bus with an address, a write strobe, write data and registered read data. Reads are always allowed. Writes to every register except the guard word are blocked until software stores a 32-bit unlock key in the guard word.

The configuration word combines bits that software writes with fields fixed at elaboration or at the pins. These fixed fields are a hardware version, an aperture code and a DRAM size code. The size code comes from a static size input given in megabytes. Two further registers reshape every word written to them, so that they always report an idle PHY and a passing ECC self-test. A parameter selects whether the PHY status word also forces its PLL-locked flag.

The guard is a two-state machine. LK_SHUT is the reset state and blocks writes. LK_OPEN lets writes through. The transitions are:
- T_UNLOCK goes from LK_SHUT to LK_OPEN when the key is written to the guard word.
- T_RELOCK goes from LK_OPEN to LK_SHUT when any other value is written to the guard word.
- T_STAY_SHUT keeps LK_SHUT when the guard word is written with a non-key value.
- T_STAY_OPEN keeps LK_OPEN when the key is written again.

Top module: `dcfg_regbank`

## Requirements
- R1: A write of 0xFC600309 to offset 0x000 makes the guard word read 1. A write of any other value there makes it read 0.
- R2: While the guard word reads 0, writes to every other offset leave the stored contents unchanged.
- R3: The register index is `bus_addr[11:2]`, and byte-offset bits 1:0 are ignored. `rd_data` shows the addressed word in the cycle after the address is presented.
- R4: Offsets at or above 0x080 (index 32 and up) read as 0. Writes to them change nothing.
- R5: After reset the following hold:
  - the guard word reads 0;
  - every plain, status and test register reads 0;
  - the configuration word (offset 0x004) holds only its fixed fields.
- R6: In the configuration word, writes cannot change the following fields:
  - bits 31:28 always equal `HW_VER`;
  - bit 19 is 1;
  - bits 18:14 are 0;
  - bit 6 is 0;
  - bits 3:2 are 2'b11.
  All other bits above bit 1 store the written value.
- R7: Configuration bits 1:0 hold the size code: 128 MB gives 0, 256 MB gives 1, 512 MB gives 2 and 1024 MB gives 3. Any other size gives 2. The code is sampled from `dram_mb` only at reset and on each accepted configuration write.
- R8: A write to offset 0x060 stores bit 0 as 0. When `PLL_FORCE` is 1 it also stores bit 4 as 1. All other bits store the written value.
- R9: A write to offset 0x070 stores bit 12 as 1 and bit 13 as 0. All other bits store the written value.
- R10: Any other in-range offset stores the written word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address within the 4 KiB window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| dram_mb | input | SIZE_W (12) | Installed DRAM size in megabytes, static |
| rd_data | output | 32 | Registered read data for the address of the previous cycle |

## Verification
The assertions assume the following about the inputs:
- `bus_addr`, `bus_wr` and `bus_wdata` are known and steady around each rising edge.
- `dram_mb` changes only while reset is held, or at least one cycle before a configuration write.

The bench meets these assumptions in three ways:
- It drives all bus inputs on the falling edge.
- It changes the size input only with reset asserted, or several idle cycles before the write that samples it.
- It holds the write strobe for exactly one cycle per access.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

    localparam logic [31:0] UNLOCK_KEY   = 32'hFC60_0309;
    localparam int          IX_LOCK      = 0;
    localparam int          IX_CONF      = 1;
    localparam int          IX_STAT      = 24;
    localparam int          IX_ECC       = 28;
    // bits software cannot set in the configuration word (version, done, reserved,
    // compat flag, aperture, size code)
    localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04F;
    localparam int          STAT_BUSY_B  = 0;
    localparam int          STAT_PLL_B   = 4;
    localparam int          ECC_DONE_B   = 12;
    localparam int          ECC_FAIL_B   = 13;

    typedef enum logic [1:0] {
        RK_PLAIN,
        RK_CONF,
        RK_STAT,
        RK_ECC
    } reg_kind_e;

    typedef enum logic {
        LK_SHUT,
        LK_OPEN
    } lock_state_e;

    function automatic reg_kind_e kind_of(input int idx);
        if (idx == IX_CONF)      return RK_CONF;
        else if (idx == IX_STAT) return RK_STAT;
        else if (idx == IX_ECC)  return RK_ECC;
        else                     return RK_PLAIN;
    endfunction

    function automatic logic [31:0] conf_fixed(input logic [3:0] ver, input logic [1:0] code);
        logic [31:0] w;
        w        = 32'h0008_000C;
        w[31:28] = ver;
        w[1:0]   = code;
        return w;
    endfunction

endpackage

// File: rtl/dcfg_size_enc.sv
module dcfg_size_enc #(
    parameter int SIZE_W = 12
) (
    input  logic [SIZE_W-1:0] dram_mb,
    output logic [1:0]        size_code
);
    localparam logic [SIZE_W-1:0] MB128  = SIZE_W'(128);
    localparam logic [SIZE_W-1:0] MB256  = SIZE_W'(256);
    localparam logic [SIZE_W-1:0] MB512  = SIZE_W'(512);
    localparam logic [SIZE_W-1:0] MB1024 = SIZE_W'(1024);

    always_comb begin
        if (dram_mb == MB128)       size_code = 2'd0;
        else if (dram_mb == MB256)  size_code = 2'd1;
        else if (dram_mb == MB512)  size_code = 2'd2;
        else if (dram_mb == MB1024) size_code = 2'd3;
        else                        size_code = 2'd2; // unknown size falls back to 512 MB
    end
endmodule

// File: rtl/dcfg_lock.sv
module dcfg_lock
    import dcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_match,
    output logic lock_open
);
    lock_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_wr && key_match)  state_d = LK_OPEN; // T_UNLOCK
            LK_OPEN: if (key_wr && !key_match) state_d = LK_SHUT; // T_RELOCK
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_SHUT: lock_open = 1'b0;
            LK_OPEN: lock_open = 1'b1;
        endcase
    end
endmodule

// File: rtl/dcfg_shape.sv
module dcfg_shape
    import dcfg_pkg::*;
#(
    parameter logic [3:0] HW_VER    = 4'd1,
    parameter bit         PLL_FORCE = 1'b1
) (
    input  reg_kind_e   kind,
    input  logic [31:0] wdata,
    input  logic [1:0]  size_code,
    output logic [31:0] shaped
);
    always_comb begin
        shaped = wdata;
        unique case (kind)
            RK_PLAIN: shaped = wdata;
            RK_CONF:  shaped = (wdata & ~CONF_RO_MASK) | conf_fixed(HW_VER, size_code);
            RK_STAT: begin
                shaped[STAT_BUSY_B] = 1'b0;
                if (PLL_FORCE) shaped[STAT_PLL_B] = 1'b1;
            end
            RK_ECC: begin
                shaped[ECC_DONE_B] = 1'b1;
                shaped[ECC_FAIL_B] = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dcfg_regbank.sv
module dcfg_regbank
    import dcfg_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         NUM_REGS  = 32,
    parameter int         SIZE_W    = 12,
    parameter logic [3:0] HW_VER    = 4'd1,
    parameter bit         PLL_FORCE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic [SIZE_W-1:0] dram_mb,
    output logic [31:0]       rd_data
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic             in_range;
    logic             key_wr;
    logic             lock_open;
    logic             wr_accept;
    logic [1:0]       size_code;
    reg_kind_e        kind;
    logic [31:0]      shaped;
    logic [31:0]      word_q [NUM_REGS];
    logic [31:0]      rd_q;
    logic [31:0]      cfg_word, stat_word, ecc_word;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign sel       = idx[SEL_W-1:0];
    assign in_range  = int'(idx) < NUM_REGS;
    assign key_wr    = bus_wr && in_range && (sel == SEL_W'(IX_LOCK));
    assign wr_accept = bus_wr && in_range && lock_open && (sel != SEL_W'(IX_LOCK));
    assign kind      = kind_of(int'(sel));

    dcfg_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_match (bus_wdata == UNLOCK_KEY),
        .lock_open (lock_open)
    );

    dcfg_size_enc #(.SIZE_W(SIZE_W)) u_size (
        .dram_mb   (dram_mb),
        .size_code (size_code)
    );

    dcfg_shape #(.HW_VER(HW_VER), .PLL_FORCE(PLL_FORCE)) u_shape (
        .kind      (kind),
        .wdata     (bus_wdata),
        .size_code (size_code),
        .shaped    (shaped)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == IX_LOCK) begin : g_guard
            assign word_q[i] = {31'b0, lock_open};
        end else if (i == IX_CONF) begin : g_conf
            logic [31:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)                               q <= conf_fixed(HW_VER, size_code);
                else if (wr_accept && sel == SEL_W'(i))   q <= shaped;
            end
            assign word_q[i] = q;
        end else begin : g_data
            logic [31:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)                               q <= '0;
                else if (wr_accept && sel == SEL_W'(i))   q <= shaped;
            end
            assign word_q[i] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= '0;
        else if (in_range) rd_q <= word_q[sel];
        else               rd_q <= '0;
    end

    assign rd_data   = rd_q;
    assign cfg_word  = word_q[IX_CONF];
    assign stat_word = word_q[IX_STAT];
    assign ecc_word  = word_q[IX_ECC];
endmodule

// File: rtl/dcfg_regbank_chk.sv
module dcfg_regbank_chk
    import dcfg_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter int         NUM_REGS  = 32,
    parameter logic [3:0] HW_VER    = 4'd1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       rd_data,
    input logic              lock_open,
    input logic [31:0]       cfg_word,
    input logic [31:0]       stat_word,
    input logic [31:0]       ecc_word
);
    int widx;
    assign widx = int'(bus_addr[ADDR_W-1:2]);

    p_key_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == IX_LOCK && bus_wdata == UNLOCK_KEY) |=> lock_open);

    p_key_shut_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == IX_LOCK && bus_wdata != UNLOCK_KEY) |=> !lock_open);

    p_locked_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_open |=> $stable(cfg_word));

    p_guard_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == IX_LOCK) |=> rd_data == {31'b0, $past(lock_open)});

    p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (widx >= NUM_REGS) |=> rd_data == 32'h0);

    p_cfg_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[31:28] == HW_VER && cfg_word[19] && cfg_word[18:14] == 5'd0
        && !cfg_word[6] && cfg_word[3:2] == 2'b11);

    p_phy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[STAT_BUSY_B]);

    p_ecc_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && lock_open && widx == IX_ECC) |=> (ecc_word[ECC_DONE_B] && !ecc_word[ECC_FAIL_B]));
endmodule

bind dcfg_regbank dcfg_regbank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .HW_VER   (HW_VER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .lock_open (lock_open),
    .cfg_word  (cfg_word),
    .stat_word (stat_word),
    .ecc_word  (ecc_word)
);

// File: tb/tb_dcfg_regbank.sv
module tb_dcfg_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [11:0] dram_mb = 12'd512;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] KEY  = 32'hFC60_0309;
    localparam logic [31:0] CFIX = 32'h1008_000C; // version 1, done bit, aperture 2'b11

    always #10 clk = ~clk; // 50 MHz

    dcfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .dram_mb(dram_mb), .rd_data(rd_data)
    );

    // {write addr, write data, read addr, expected, requirement number}
    localparam int NV = 13;
    localparam logic [95:0] VEC [NV] = '{
        {12'h004, 32'hFFFF_FFFF, 12'h004, 32'h1FF8_3FBE, 8'd6},  // R6
        {12'h004, 32'hA5A5_A5A5, 12'h004, 32'h15A8_25AE, 8'd6},  // R6
        {12'h004, 32'h0000_0000, 12'h004, 32'h1008_000E, 8'd6},  // R6
        {12'h060, 32'hFFFF_FFFF, 12'h060, 32'hFFFF_FFFE, 8'd8},  // R8
        {12'h060, 32'h0000_0001, 12'h060, 32'h0000_0010, 8'd8},  // R8
        {12'h070, 32'hFFFF_FFFF, 12'h070, 32'hFFFF_DFFF, 8'd9},  // R9
        {12'h070, 32'h0000_0000, 12'h070, 32'h0000_1000, 8'd9},  // R9
        {12'h008, 32'hDEAD_BEEF, 12'h008, 32'hDEAD_BEEF, 8'd10}, // R10
        {12'h07C, 32'h1234_5678, 12'h07C, 32'h1234_5678, 8'd10}, // R10
        {12'h00E, 32'h0BAD_F00D, 12'h00C, 32'h0BAD_F00D, 8'd3},  // R3
        {12'h040, 32'hCAFE_F00D, 12'h043, 32'hCAFE_F00D, 8'd3},  // R3
        {12'h080, 32'h0000_0055, 12'h080, 32'h0000_0000, 8'd4},  // R4
        {12'hFFC, 32'h0000_0077, 12'hFFC, 32'h0000_0000, 8'd4}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        @(negedge clk); // one registered stage
        chk(tag, rd_data, exp);
    endtask

    task automatic do_reset(input logic [11:0] mb);
        @(negedge clk);
        rst_n   = 1'b0;
        dram_mb = mb;
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
    endtask

    initial begin
        do_reset(12'd512);
        // R5 reset state
        chk("R5 rd_data after reset", rd_data, 32'h0);
        rd_chk(12'h000, 32'h0, "R5 guard");
        rd_chk(12'h004, CFIX | 32'd2, "R5 config");
        rd_chk(12'h060, 32'h0, "R5 status");
        rd_chk(12'h070, 32'h0, "R5 ecc test");
        rd_chk(12'h07C, 32'h0, "R5 last word");

        // R2 locked writes are dropped
        wr(12'h008, 32'h0001_2345);
        rd_chk(12'h008, 32'h0, "R2 plain word while locked");
        wr(12'h004, 32'hFFFF_FFFF);
        rd_chk(12'h004, CFIX | 32'd2, "R2 config while locked");
        wr(12'h070, 32'h0);
        rd_chk(12'h070, 32'h0, "R2 ecc while locked");

        // R1 key handling
        wr(12'h000, 32'hFC60_0308);
        rd_chk(12'h000, 32'h0, "R1 near-miss key");
        wr(12'h000, KEY);
        rd_chk(12'h000, 32'h1, "R1 unlock");
        wr(12'h001, KEY); // byte offset ignored, still guard word (R3)
        rd_chk(12'h003, 32'h1, "R3 guard via byte offset");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][95:84], VEC[i][83:52]);
            rd_chk(VEC[i][51:40], VEC[i][39:8], $sformatf("R%0d vector %0d", VEC[i][7:0], i));
        end

        // R4 out-of-range writes did not alias onto low words
        rd_chk(12'h000, 32'h1, "R4 guard untouched");
        rd_chk(12'h07C, 32'h1234_5678, "R4 word 31 untouched");

        // R1/R2 relock
        wr(12'h000, 32'h0);
        rd_chk(12'h000, 32'h0, "R1 relock");
        wr(12'h008, 32'h0000_0001);
        rd_chk(12'h008, 32'hDEAD_BEEF, "R2 write after relock");

        // R7 size encoding sampled at reset
        do_reset(12'd128);  rd_chk(12'h004, CFIX | 32'd0, "R7 128MB");
        do_reset(12'd256);  rd_chk(12'h004, CFIX | 32'd1, "R7 256MB");
        do_reset(12'd1024); rd_chk(12'h004, CFIX | 32'd3, "R7 1024MB");
        do_reset(12'd1000); rd_chk(12'h004, CFIX | 32'd2, "R7 odd size fallback");
        do_reset(12'd2048); rd_chk(12'h004, CFIX | 32'd2, "R7 2048MB fallback");
        do_reset(12'd128);
        rd_chk(12'h008, 32'h0, "R5 plain word cleared by reset");
        @(negedge clk) dram_mb = 12'd1024;
        repeat (2) @(negedge clk);
        rd_chk(12'h004, CFIX | 32'd0, "R7 no resample without write");
        wr(12'h000, KEY);
        wr(12'h004, 32'h0000_0003);
        rd_chk(12'h004, CFIX | 32'd3, "R7 resample on config write");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule